// File: doc/BRIEF.md
# Instruction Fetch Address Translator

This block turns the address of an instruction fetch into a physical address. Each request carries the low bit of the fetch PC, the virtual address, a physical-mode flag, the current privilege mode and the address-space number. One clock after the request the block raises `done_o` with the physical address, an uncacheable flag and a one-hot fault code. The fault code has four bits: bit 0 is access violation, bit 1 is page miss, bit 2 is machine check and bit 3 is unimplemented. An all-zero code means the fetch may proceed.

The block does not hold the translation table. During the request cycle it drives the virtual page number and the address-space number to an external lookup array. In the same cycle it takes back a hit flag, a physical page number and a 4-bit execute-enable mask with one bit per mode. A fetch can take one of four routes, in falling priority:

- a privileged-code bypass, taken when the PC low bit is set;
- a physical pass-through;
- a kernel-only direct-mapped window;
- the table lookup.

Every route except the bypass then passes a physical address check and an uncacheable-region check. Three wrapping counters record hits, misses and access violations. Raising and dispatching the exception is left to the fetch unit.

Top module: `fetch_xlate`

## Requirements
- R1: While reset is high and in the cycle after it, `done_o` is 0, `fault_o` is 0 and all three counters read 0.
- R2: When `pc_lsb_i` is 1, the result is the virtual address with bits 1:0 cleared and only bits 43:0 kept. There is no fault and no uncacheable flag. The physical flag, address validity and the post checks are ignored, and the hit counter goes up by one.
- R3: When `pc_lsb_i` is 0 and `phys_i` is 1, the virtual address is used unchanged as the physical address before the post checks.
- R4: On the translated routes, a virtual address whose bits 63:47 are not all equal gives fault 4'b0001.
- R5: A canonical address with bits 47:41 equal to 7'h7e is direct-mapped if the mode is kernel (mode 0). In modes 1, 2 or 3 it gives fault 4'b0001. Mode encoding: kernel 0, executive 1, supervisor 2, user 3.
- R6: In the direct-mapped window the address is first cut to bits 43:0. If bit 40 is then 1, bits 43:40 are set to ones; otherwise every bit from 40 upward is cleared.
- R7: On any other translated address, `tlb_vpn_o` carries VA bits 47:13 and `tlb_asn_o` carries `asn_i`. If `tlb_hit_i` is 0 the fault is page miss, 4'b0010, and the miss counter goes up by one.
- R8: On a table hit the physical address is the page number shifted left by 13, OR'd with VA bits 12:2 and two zero bits. If the execute check passes, the hit counter goes up by one.
- R9: On a table hit, a 0 in `tlb_xre_i` at bit position `mode_i` gives fault 4'b0001 and no hit count.
- R10: After any route except the bypass, an address with any bit above 43 set gives fault 4'b0100.
- R11: Otherwise, if bit 43 is set, the fault is 4'b1000 when bits 43:36 are all ones. If they are not, `uncached_o` is 1 and bits 42:35 are cleared.
- R12: `done_o` is high exactly in the cycle after a request, and `fault_o` has at most one bit set. When a fault is reported, `pa_o` reads 0.
- R13: Every access-violation fault adds one to the violation counter, and the counters change on no other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Translate request, one cycle |
| pc_lsb_i | input | 1 | Least significant bit of the fetch PC |
| phys_i | input | 1 | Physical-mode flag |
| va_i | input | 64 | Virtual fetch address |
| mode_i | input | 2 | Current privilege mode |
| asn_i | input | 8 | Address-space number |
| tlb_vpn_o | output | 35 | Page number presented to the lookup array |
| tlb_asn_o | output | 8 | Address-space number presented to the lookup array |
| tlb_hit_i | input | 1 | Lookup hit, same cycle |
| tlb_ppn_i | input | 32 | Physical page number of the hit entry |
| tlb_xre_i | input | 4 | Execute-enable mask of the hit entry, one bit per mode |
| done_o | output | 1 | Result valid |
| pa_o | output | 44 | Physical address |
| uncached_o | output | 1 | Access is uncacheable |
| fault_o | output | 4 | One-hot fault code |
| hit_cnt_o | output | 16 | Hit counter |
| miss_cnt_o | output | 16 | Miss counter |
| acv_cnt_o | output | 16 | Access-violation counter |

## Verification
Window sign extension and the uncacheable-region check can act in the same cycle. A window fetch with bit 40 set acquires bit 43 through the extension, and that bit then drives the uncacheable clearing. The bench provokes this with a kernel window address whose bits 39:36 are not all ones, and expects bits 42:35 cleared with the uncacheable flag set. Two other pairs are also made to coincide:

- A table hit whose page number lands above bit 43 or inside the internal-register region must still count a hit while reporting machine check or unimplemented.
- A bypass fetch with the physical flag also set must take the bypass result.

// File: rtl/fx_pkg.sv
package fx_pkg;
  localparam int FLT_W     = 4;
  localparam int FLT_ACV   = 0;
  localparam int FLT_MISS  = 1;
  localparam int FLT_MCHK  = 2;
  localparam int FLT_UNIMP = 3;

  localparam int MODE_W    = 2;
  localparam int NUM_MODES = 1 << MODE_W;

  typedef enum logic [MODE_W-1:0] {
    MODE_KERN = 2'd0,
    MODE_EXEC = 2'd1,
    MODE_SUPV = 2'd2,
    MODE_USER = 2'd3
  } cpu_mode_e;

  localparam int CNT_HIT  = 0;
  localparam int CNT_MISS = 1;
  localparam int CNT_ACV  = 2;
  localparam int NUM_CNT  = 3;
endpackage

// File: rtl/fx_route.sv
module fx_route import fx_pkg::*; #(
  parameter int VA_W     = 64,
  parameter int PA_W     = 44,
  parameter int VA_IMPL  = 48,
  parameter int PG_SHIFT = 13,
  parameter int PPN_W    = 32,
  parameter int SP_HI    = 47,
  parameter int SP_LO    = 41,
  parameter int SP_TAG   = 126,
  parameter int SX_BIT   = 40
) (
  input  logic                 pc_lsb,
  input  logic                 phys,
  input  logic [VA_W-1:0]      va,
  input  logic [MODE_W-1:0]    mode,
  input  logic                 tlb_hit,
  input  logic [PPN_W-1:0]     tlb_ppn,
  input  logic [NUM_MODES-1:0] tlb_xre,
  output logic [VA_W-1:0]      pa_raw,
  output logic [FLT_W-1:0]     early_fault,
  output logic                 need_post,
  output logic [NUM_CNT-1:0]   cnt_inc
);
  localparam int SP_W = SP_HI - SP_LO + 1;
  localparam logic [VA_W-1:0] IMPL_MASK = (VA_W'(1) << PA_W) - VA_W'(1);
  localparam logic [VA_W-1:0] LO_KEEP   = (VA_W'(1) << SX_BIT) - VA_W'(1);
  localparam logic [VA_W-1:0] HI_ONES   = IMPL_MASK & ~LO_KEEP;

  logic            va_canon;
  logic            in_window;
  logic [VA_W-1:0] bypass_pa;
  logic [VA_W-1:0] win_base;
  logic [VA_W-1:0] window_pa;
  logic [VA_W-1:0] table_pa;

  assign va_canon  = (&va[VA_W-1:VA_IMPL-1]) | (~|va[VA_W-1:VA_IMPL-1]);
  assign in_window = (va[SP_HI:SP_LO] == SP_W'(SP_TAG));
  assign bypass_pa = {va[VA_W-1:2], 2'b00} & IMPL_MASK;
  assign win_base  = va & IMPL_MASK;
  assign window_pa = win_base[SX_BIT] ? (win_base | HI_ONES) : (win_base & LO_KEEP);
  assign table_pa  = VA_W'({tlb_ppn, va[PG_SHIFT-1:2], 2'b00});

  always_comb begin
    pa_raw      = '0;
    early_fault = '0;
    need_post   = 1'b0;
    cnt_inc     = '0;
    if (pc_lsb) begin
      pa_raw           = bypass_pa;
      cnt_inc[CNT_HIT] = 1'b1;
    end else if (phys) begin
      pa_raw    = va;
      need_post = 1'b1;
    end else if (!va_canon) begin
      early_fault[FLT_ACV] = 1'b1;
      cnt_inc[CNT_ACV]     = 1'b1;
    end else if (in_window) begin
      if (mode != MODE_KERN) begin
        early_fault[FLT_ACV] = 1'b1;
        cnt_inc[CNT_ACV]     = 1'b1;
      end else begin
        pa_raw    = window_pa;
        need_post = 1'b1;
      end
    end else if (!tlb_hit) begin
      early_fault[FLT_MISS] = 1'b1;
      cnt_inc[CNT_MISS]     = 1'b1;
    end else if (!tlb_xre[mode]) begin
      early_fault[FLT_ACV] = 1'b1;
      cnt_inc[CNT_ACV]     = 1'b1;
    end else begin
      pa_raw           = table_pa;
      need_post        = 1'b1;
      cnt_inc[CNT_HIT] = 1'b1;
    end
  end
endmodule

// File: rtl/fx_postchk.sv
module fx_postchk #(
  parameter int VA_W    = 64,
  parameter int PA_W    = 44,
  parameter int IPR_LO  = 36,
  parameter int UCLR_HI = 42,
  parameter int UCLR_LO = 35
) (
  input  logic [VA_W-1:0] pa_raw,
  input  logic            need_post,
  output logic [PA_W-1:0] pa_fin,
  output logic            mchk,
  output logic            unimp,
  output logic            uncached
);
  localparam logic [PA_W-1:0] UCLR_MASK =
    ((PA_W'(1) << (UCLR_HI + 1)) - PA_W'(1)) & ~((PA_W'(1) << UCLR_LO) - PA_W'(1));

  logic over;
  logic ipr;
  logic hi_bit;

  assign over   = |pa_raw[VA_W-1:PA_W];
  assign ipr    = &pa_raw[PA_W-1:IPR_LO];
  assign hi_bit = pa_raw[PA_W-1];

  assign mchk     = need_post & over;
  assign unimp    = need_post & ~over & hi_bit & ipr;
  assign uncached = need_post & ~over & hi_bit & ~ipr;
  assign pa_fin   = uncached ? (pa_raw[PA_W-1:0] & ~UCLR_MASK) : pa_raw[PA_W-1:0];
endmodule

// File: rtl/fx_counters.sv
module fx_counters #(
  parameter int N     = 3,
  parameter int CNT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N-1:0]            inc,
  output logic [N-1:0][CNT_W-1:0] cnt
);
  for (genvar g = 0; g < N; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst) cnt[g] <= '0;
      else if (inc[g]) cnt[g] <= cnt[g] + CNT_W'(1);
    end
  end
endmodule

// File: rtl/fetch_xlate.sv
module fetch_xlate import fx_pkg::*; #(
  parameter int VA_W     = 64,
  parameter int PA_W     = 44,
  parameter int VA_IMPL  = 48,
  parameter int PG_SHIFT = 13,
  parameter int PPN_W    = 32,
  parameter int ASN_W    = 8,
  parameter int CNT_W    = 16,
  parameter int SP_HI    = 47,
  parameter int SP_LO    = 41,
  parameter int SP_TAG   = 126,
  parameter int SX_BIT   = 40,
  parameter int IPR_LO   = 36,
  parameter int UCLR_HI  = 42,
  parameter int UCLR_LO  = 35,
  localparam int VPN_W   = VA_IMPL - PG_SHIFT
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_i,
  input  logic                 pc_lsb_i,
  input  logic                 phys_i,
  input  logic [VA_W-1:0]      va_i,
  input  logic [1:0]           mode_i,
  input  logic [ASN_W-1:0]     asn_i,
  output logic [VPN_W-1:0]     tlb_vpn_o,
  output logic [ASN_W-1:0]     tlb_asn_o,
  input  logic                 tlb_hit_i,
  input  logic [PPN_W-1:0]     tlb_ppn_i,
  input  logic [3:0]           tlb_xre_i,
  output logic                 done_o,
  output logic [PA_W-1:0]      pa_o,
  output logic                 uncached_o,
  output logic [3:0]           fault_o,
  output logic [CNT_W-1:0]     hit_cnt_o,
  output logic [CNT_W-1:0]     miss_cnt_o,
  output logic [CNT_W-1:0]     acv_cnt_o
);
  logic [VA_W-1:0]             pa_raw;
  logic [FLT_W-1:0]            early_fault;
  logic                        need_post;
  logic [NUM_CNT-1:0]          cnt_inc;
  logic [PA_W-1:0]             pa_fin;
  logic                        mchk;
  logic                        unimp;
  logic                        uncached;
  logic [FLT_W-1:0]            all_fault;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt;

  assign tlb_vpn_o = va_i[VA_IMPL-1:PG_SHIFT];
  assign tlb_asn_o = asn_i;

  fx_route #(
    .VA_W(VA_W), .PA_W(PA_W), .VA_IMPL(VA_IMPL), .PG_SHIFT(PG_SHIFT),
    .PPN_W(PPN_W), .SP_HI(SP_HI), .SP_LO(SP_LO), .SP_TAG(SP_TAG), .SX_BIT(SX_BIT)
  ) u_route (
    .pc_lsb(pc_lsb_i), .phys(phys_i), .va(va_i), .mode(mode_i),
    .tlb_hit(tlb_hit_i), .tlb_ppn(tlb_ppn_i), .tlb_xre(tlb_xre_i),
    .pa_raw(pa_raw), .early_fault(early_fault), .need_post(need_post),
    .cnt_inc(cnt_inc)
  );

  fx_postchk #(
    .VA_W(VA_W), .PA_W(PA_W), .IPR_LO(IPR_LO), .UCLR_HI(UCLR_HI), .UCLR_LO(UCLR_LO)
  ) u_post (
    .pa_raw(pa_raw), .need_post(need_post), .pa_fin(pa_fin),
    .mchk(mchk), .unimp(unimp), .uncached(uncached)
  );

  always_comb begin
    all_fault            = early_fault;
    all_fault[FLT_MCHK]  = mchk;
    all_fault[FLT_UNIMP] = unimp;
  end

  fx_counters #(.N(NUM_CNT), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst),
    .inc(cnt_inc & {NUM_CNT{req_i}}),
    .cnt(cnt)
  );

  assign hit_cnt_o  = cnt[CNT_HIT];
  assign miss_cnt_o = cnt[CNT_MISS];
  assign acv_cnt_o  = cnt[CNT_ACV];

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o     <= 1'b0;
      fault_o    <= '0;
      uncached_o <= 1'b0;
      pa_o       <= '0;
    end else begin
      done_o     <= req_i;
      fault_o    <= req_i ? all_fault : '0;
      uncached_o <= req_i & uncached;
      if (req_i) pa_o <= (|all_fault) ? '0 : pa_fin;
    end
  end

  // R12
  done_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_i |=> done_o);

  // R12
  fault_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fault_o));

  // R11
  uc_clears_field_chk: assert property (@(posedge clk) disable iff (rst)
    uncached_o |-> (pa_o[UCLR_HI:UCLR_LO] == '0) && (fault_o == '0));

  // R13
  acv_cnt_moves_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(acv_cnt_o) |-> done_o && fault_o[FLT_ACV]);

  // R7
  miss_cnt_moves_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(miss_cnt_o) |-> done_o && fault_o[FLT_MISS]);

  // R8
  hit_cnt_moves_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(hit_cnt_o) |-> done_o && !fault_o[FLT_ACV] && !fault_o[FLT_MISS]);
endmodule

// File: tb/tb_fetch_xlate.sv
module tb_fetch_xlate;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_i, pc_lsb_i, phys_i;
  logic [63:0] va_i;
  logic [1:0]  mode_i;
  logic [7:0]  asn_i;
  logic [34:0] tlb_vpn_o;
  logic [7:0]  tlb_asn_o;
  logic        tlb_hit_i;
  logic [31:0] tlb_ppn_i;
  logic [3:0]  tlb_xre_i;
  logic        done_o, uncached_o;
  logic [43:0] pa_o;
  logic [3:0]  fault_o;
  logic [15:0] hit_cnt_o, miss_cnt_o, acv_cnt_o;

  always #5 clk = ~clk;

  fetch_xlate dut (
    .clk(clk), .rst(rst), .req_i(req_i), .pc_lsb_i(pc_lsb_i), .phys_i(phys_i),
    .va_i(va_i), .mode_i(mode_i), .asn_i(asn_i), .tlb_vpn_o(tlb_vpn_o),
    .tlb_asn_o(tlb_asn_o), .tlb_hit_i(tlb_hit_i), .tlb_ppn_i(tlb_ppn_i),
    .tlb_xre_i(tlb_xre_i), .done_o(done_o), .pa_o(pa_o), .uncached_o(uncached_o),
    .fault_o(fault_o), .hit_cnt_o(hit_cnt_o), .miss_cnt_o(miss_cnt_o),
    .acv_cnt_o(acv_cnt_o)
  );

  // lookup array model
  localparam logic [34:0] T_VPN [5] = '{35'h10, 35'h20, 35'h30, 35'h40, 35'h50};
  localparam logic [7:0]  T_ASN [5] = '{8'd5, 8'd5, 8'd5, 8'd5, 8'd7};
  localparam logic [31:0] T_PPN [5] = '{32'h123, 32'h4000_0000, 32'h8000_0000,
                                        32'h7F80_0001, 32'h55};
  localparam logic [3:0]  T_XRE [5] = '{4'b0001, 4'b1111, 4'b1111, 4'b1111, 4'b1111};

  always_comb begin
    tlb_hit_i = 1'b0;
    tlb_ppn_i = '0;
    tlb_xre_i = '0;
    for (int k = 0; k < 5; k++) begin
      if (tlb_vpn_o == T_VPN[k] && tlb_asn_o == T_ASN[k]) begin
        tlb_hit_i = 1'b1;
        tlb_ppn_i = T_PPN[k];
        tlb_xre_i = T_XRE[k];
      end
    end
  end

  typedef struct packed {
    logic        pc;
    logic        ph;
    logic [1:0]  md;
    logic [63:0] va;
    logic [3:0]  ef;
    logic        eu;
    logic [43:0] ep;
    logic [1:0]  cc;   // 0 none, 1 hit, 2 miss, 3 violation
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 2'd0, 64'hFFFF_0ABC_DEF0_1237, 4'b0000, 1'b0, 44'hABC_DEF0_1234, 2'd1, 8'd2},  // R2
    '{1'b0, 1'b1, 2'd0, 64'h0000_0000_0012_3456, 4'b0000, 1'b0, 44'h000_0012_3456, 2'd0, 8'd3},  // R3
    '{1'b0, 1'b1, 2'd0, 64'h0001_0000_0000_0000, 4'b0100, 1'b0, 44'h0,             2'd0, 8'd10}, // R10
    '{1'b0, 1'b1, 2'd0, 64'h0000_0C12_3456_7890, 4'b0000, 1'b1, 44'h802_3456_7890, 2'd0, 8'd11}, // R11
    '{1'b0, 1'b1, 2'd0, 64'h0000_0FF0_0000_0040, 4'b1000, 1'b0, 44'h0,             2'd0, 8'd11}, // R11
    '{1'b0, 1'b0, 2'd0, 64'h0001_0000_0000_0000, 4'b0001, 1'b0, 44'h0,             2'd3, 8'd4},  // R4
    '{1'b0, 1'b0, 2'd0, 64'hFFFF_FC00_1234_5678, 4'b0000, 1'b0, 44'h000_1234_5678, 2'd0, 8'd6},  // R6
    '{1'b0, 1'b0, 2'd0, 64'hFFFF_FD01_2345_6788, 4'b0000, 1'b1, 44'h801_2345_6788, 2'd0, 8'd6},  // R6
    '{1'b0, 1'b0, 2'd3, 64'hFFFF_FC00_1234_5678, 4'b0001, 1'b0, 44'h0,             2'd3, 8'd5},  // R5
    '{1'b0, 1'b0, 2'd0, 64'h0000_0000_0002_01AB, 4'b0000, 1'b0, 44'h000_0024_61A8, 2'd1, 8'd8},  // R8
    '{1'b0, 1'b0, 2'd1, 64'h0000_0000_0002_01AB, 4'b0001, 1'b0, 44'h0,             2'd3, 8'd9},  // R9
    '{1'b0, 1'b0, 2'd0, 64'h0000_0000_000A_0000, 4'b0010, 1'b0, 44'h0,             2'd2, 8'd7},  // R7
    '{1'b0, 1'b0, 2'd3, 64'h0000_0000_0004_0007, 4'b0000, 1'b1, 44'h800_0000_0004, 2'd1, 8'd11}, // R11
    '{1'b0, 1'b0, 2'd0, 64'h0000_0000_0006_0000, 4'b0100, 1'b0, 44'h0,             2'd1, 8'd10}, // R10
    '{1'b0, 1'b0, 2'd0, 64'h0000_0000_0008_0000, 4'b1000, 1'b0, 44'h0,             2'd1, 8'd11}, // R11
    '{1'b1, 1'b1, 2'd3, 64'h0000_0000_0000_1007, 4'b0000, 1'b0, 44'h000_0000_1004, 2'd1, 8'd2}   // R2
  };

  int applied = 0;
  int miscmp  = 0;
  bit ended   = 1'b0;
  int exp_hit = 0, exp_miss = 0, exp_acv = 0;

  task automatic chk(input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    applied++;
    if (act !== exp) begin
      miscmp++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    ended = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      miscmp++;
      $display("FAIL R12 watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    rst = 1'b1; req_i = 0; pc_lsb_i = 0; phys_i = 0; va_i = '0; mode_i = 0; asn_i = 8'd5;
    repeat (4) @(negedge clk);
    // R1: state while held in reset
    chk("R1", "done in reset", 64'(done_o), 64'd0);
    chk("R1", "fault in reset", 64'(fault_o), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "hit count after reset", 64'(hit_cnt_o), 64'd0);
    chk("R1", "acv count after reset", 64'(acv_cnt_o), 64'd0);
    chk("R1", "done after reset", 64'(done_o), 64'd0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", VEC[i].rq);
      pc_lsb_i = VEC[i].pc; phys_i = VEC[i].ph; mode_i = VEC[i].md; va_i = VEC[i].va;
      req_i = 1'b1;
      @(negedge clk);
      chk(tag, $sformatf("v%0d done", i), 64'(done_o), 64'd1);
      chk(tag, $sformatf("v%0d fault", i), 64'(fault_o), 64'(VEC[i].ef));
      chk(tag, $sformatf("v%0d uncached", i), 64'(uncached_o), 64'(VEC[i].eu));
      chk(tag, $sformatf("v%0d pa", i), 64'(pa_o), 64'(VEC[i].ep));
      if (VEC[i].cc == 2'd1) exp_hit++;
      if (VEC[i].cc == 2'd2) exp_miss++;
      if (VEC[i].cc == 2'd3) exp_acv++;
      req_i = 1'b0;
    end

    // R12: done drops when no request
    @(negedge clk);
    chk("R12", "done idle", 64'(done_o), 64'd0);
    chk("R12", "fault idle", 64'(fault_o), 64'd0);

    // R13 and R8, R7: counter totals
    chk("R13", "acv count", 64'(acv_cnt_o), 64'(exp_acv));
    chk("R8", "hit count", 64'(hit_cnt_o), 64'(exp_hit));
    chk("R7", "miss count", 64'(miss_cnt_o), 64'(exp_miss));

    // R7: lookup key presented combinationally
    va_i = 64'h0000_0000_0002_01AB; asn_i = 8'd9;
    #1;
    chk("R7", "lookup vpn", 64'(tlb_vpn_o), 64'h10);
    chk("R7", "lookup asn", 64'(tlb_asn_o), 64'd9);
    asn_i = 8'd5;

    // R1: reset mid-run clears counters
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1", "hit count cleared", 64'(hit_cnt_o), 64'd0);
    chk("R1", "miss count cleared", 64'(miss_cnt_o), 64'd0);
    chk("R1", "acv count cleared", 64'(acv_cnt_o), 64'd0);

    finish_run();
  end
endmodule